// File: doc/BRIEF.md
# Serial Bus Hold Pause Controller

This block sits between the raw pins of a serial memory port and the core shift engine. It lets a host that shares the serial clock freeze a transaction part way through, then pick it up again at the same bit. The host does this by pulling the hold line low. The shift engine never sees the pause. It receives one-cycle clock-enable pulses for each accepted SCK rising and falling edge. It also receives a register of captured data lanes, and a request to force the output driver to high-Z. It never receives a reset.

The pins are sampled on a fast system clock through a synchronizer. In single-bit and dual modes, lane 3 of the I/O bus doubles as the active-low hold line. Entry into hold depends on the SCK level. A hold request seen while SCK is low takes effect at once. A hold request seen while SCK is high waits for the next SCK falling edge, and that edge is consumed by the hold. In quad mode, lane 3 is plain data and the hold function is switched off. A high chip select aborts any hold in progress.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After a synchronous reset, `core_rise_en` and `core_fall_en` are 0, `core_din` is 0, `out_hiz` is 1 and `hold_active` is 0.
- R2: With `cs_n` low and the hold line high, every SCK rising or falling edge at the pins gives exactly one single-cycle pulse on `core_rise_en` or `core_fall_en`. The pulse appears SYNC_STAGES+1 clock edges after the pins change.
- R3: On an accepted rising edge, `core_din` loads the lanes that the mode uses. The mode encoding is 00 single (lane 0), 01 dual (lanes 0 and 1), 10 quad (lanes 0 to 3) and 11 treated as single. Unused lanes load as 0.
- R4: In a non-quad mode, a low hold line (lane 3) sampled while SCK is low enters hold at once. Any SCK edge in that sample or during hold gives no enable pulse.
- R5: A low hold line sampled while SCK is high leaves `hold_active` at 0 until the next SCK falling edge. That falling edge gives no pulse and enters hold.
- R6: In a non-quad mode, `out_hiz` is 1 in the same cycle that a sampled low hold line would first affect the enables, even while entry is still deferred.
- R7: Hold is left only in a sample where the hold line is high and SCK is low. If the hold line rises while SCK is high, the block stays in hold until SCK goes low. After leaving hold, edges again produce pulses.
- R8: In quad mode (10), lane 3 low has no effect: edges still pulse, `hold_active` stays 0 and `out_hiz` stays 0.
- R9: `cs_n` high suppresses all pulses, sets `out_hiz` to 1 and clears any pending or active hold.
- R10: If the hold line returns high before a deferred entry has taken effect, the entry is cancelled and the next falling edge pulses normally.
- R11: `core_din` does not change while `hold_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Raw serial clock pin |
| cs_n | input | 1 | Raw active-low chip select pin |
| sio_in | input | LANES | Raw data lanes; lane 3 is the active-low hold line outside quad mode |
| mode | input | 2 | Lane mode: 00 single, 01 dual, 10 quad, 11 single |
| core_rise_en | output | 1 | One-cycle enable for an accepted SCK rising edge |
| core_fall_en | output | 1 | One-cycle enable for an accepted SCK falling edge |
| core_din | output | LANES | Lanes captured on the last accepted rising edge |
| out_hiz | output | 1 | Forces the serial output driver to high-Z |
| hold_active | output | 1 | The transaction is paused |

## Verification
Two functions can act in the same sample: hold entry and the SCK edge detector. The bench provokes this by changing the hold line and SCK at the same instant, once with SCK falling and once with SCK rising. In both cases the edge must be swallowed, not passed to the core, and the resulting state must be immediate hold or pending hold. A second collision is the hold line rising while SCK is still high. There the exit must wait for the later falling edge, and that edge must give no pulse. A behavioural reference model with a sample queue predicts every output on every clock, and targeted counter checks confirm the pulse totals across each pause.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [1:0] {
    LM_SINGLE = 2'b00,
    LM_DUAL   = 2'b01,
    LM_QUAD   = 2'b10,
    LM_ALT    = 2'b11
  } lane_mode_e;

  typedef enum logic [1:0] {
    HS_RUN  = 2'b00,
    HS_PEND = 2'b01,
    HS_HELD = 2'b10
  } hold_state_e;

  function automatic int unsigned lanes_for_mode(lane_mode_e m, int unsigned total);
    case (m)
      LM_DUAL: return 2;
      LM_QUAD: return total;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 6,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= IDLE;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= IDLE;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s_sck,
  input  logic s_cs_n,
  input  logic s_hold_n,
  input  logic hold_ok,
  output logic take_rise,
  output logic rise_en,
  output logic fall_en,
  output logic out_hiz,
  output logic held
);

  hold_state_e state_q, state_d;
  logic        sck_prev;
  logic        edge_up, edge_dn, pass_ok;

  assign edge_up = s_sck & ~sck_prev;
  assign edge_dn = ~s_sck & sck_prev;
  assign pass_ok = ~s_cs_n & (~hold_ok | (s_hold_n & (state_q != HS_HELD)));
  assign take_rise = edge_up & pass_ok;

  always_comb begin
    state_d = state_q;
    if (s_cs_n || !hold_ok) begin
      state_d = HS_RUN;
    end else begin
      case (state_q)
        HS_RUN:  if (!s_hold_n) state_d = s_sck ? HS_PEND : HS_HELD;
        HS_PEND: begin
          if (s_hold_n)     state_d = HS_RUN;
          else if (edge_dn) state_d = HS_HELD;
        end
        HS_HELD: if (s_hold_n && !s_sck) state_d = HS_RUN;
        default: state_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= HS_RUN;
      sck_prev <= 1'b0;
      rise_en  <= 1'b0;
      fall_en  <= 1'b0;
      out_hiz  <= 1'b1;
    end else begin
      state_q  <= state_d;
      sck_prev <= s_sck;
      rise_en  <= edge_up & pass_ok;
      fall_en  <= edge_dn & pass_ok;
      out_hiz  <= s_cs_n | (hold_ok & (~s_hold_n | (state_q == HS_HELD)));
    end
  end

  assign held = (state_q == HS_HELD);

  // R4: a paused transaction passes no edge to the core
  p_no_edge_in_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_HELD) |=> (!rise_en && !fall_en));

  // R5: a deferred entry completes on the falling edge
  p_pend_to_held_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_PEND && edge_dn && !s_hold_n && !s_cs_n && hold_ok)
      |=> (held && !fall_en));

  // R6: driver released as soon as the hold line is seen low
  p_hiz_on_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_ok && !s_hold_n) |=> out_hiz);

  // R7: no exit while SCK is still high
  p_stay_held_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_HELD && s_sck && !s_cs_n && hold_ok) |=> held);

  // R9: chip select high clears the pause and blocks the core
  p_cs_abort_r9: assert property (@(posedge clk) disable iff (rst)
    s_cs_n |=> (!held && out_hiz && !rise_en && !fall_en));

endmodule

// File: rtl/hold_lane_capture.sv
module hold_lane_capture
  import hold_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  lane_mode_e       mode,
  input  logic [LANES-1:0] s_din,
  output logic [LANES-1:0] core_din
);

  logic [LANES-1:0] lane_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lane_mask[i] = (i < lanes_for_mode(mode, LANES));
  end

  always_ff @(posedge clk) begin
    if (rst)       core_din <= '0;
    else if (take) core_din <= s_din & lane_mask;
  end

  // R3: single-lane modes never show upper lanes
  p_single_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (take && (mode == LM_SINGLE || mode == LM_ALT)) |=> (core_din[LANES-1:1] == '0));

endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
  import hold_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic [LANES-1:0] sio_in,
  input  logic [1:0]       mode,
  output logic             core_rise_en,
  output logic             core_fall_en,
  output logic [LANES-1:0] core_din,
  output logic             out_hiz,
  output logic             hold_active
);

  localparam int unsigned HOLD_LANE = 3;
  localparam int unsigned SW        = LANES + 2;
  localparam logic [SW-1:0] PIN_IDLE = {1'b1, 1'b0, {LANES{1'b1}}};

  logic [SW-1:0]    pins_s;
  logic [LANES-1:0] s_din;
  logic             s_sck, s_cs_n, s_hold_n, hold_ok, take;
  lane_mode_e       mode_e;

  assign mode_e = lane_mode_e'(mode);

  hold_sync #(.STAGES(SYNC_STAGES), .WIDTH(SW), .IDLE(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, sio_in}),
    .q   (pins_s)
  );

  assign s_din    = pins_s[LANES-1:0];
  assign s_sck    = pins_s[LANES];
  assign s_cs_n   = pins_s[LANES+1];
  assign s_hold_n = s_din[HOLD_LANE];
  assign hold_ok  = (mode_e != LM_QUAD);

  hold_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .s_sck     (s_sck),
    .s_cs_n    (s_cs_n),
    .s_hold_n  (s_hold_n),
    .hold_ok   (hold_ok),
    .take_rise (take),
    .rise_en   (core_rise_en),
    .fall_en   (core_fall_en),
    .out_hiz   (out_hiz),
    .held      (hold_active)
  );

  hold_lane_capture #(.LANES(LANES)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .mode     (mode_e),
    .s_din    (s_din),
    .core_din (core_din)
  );

  // R11: captured lanes frozen through a pause
  p_din_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    hold_active |=> $stable(core_din));

  // R2: the two enables never pulse together
  p_one_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !(core_rise_en && core_fall_en));

  // R8: quad mode never pauses
  p_quad_no_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_e == LM_QUAD && $stable(mode)) |=> !hold_active);

endmodule

// File: tb/tb_hold_pause_ctrl.sv
module tb_hold_pause_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int SYNC       = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sck = 1'b0;
  logic             cs_n = 1'b1;
  logic [LANES-1:0] sio = 4'hF;
  logic [1:0]       mode = 2'b00;
  logic             core_rise_en, core_fall_en, out_hiz, hold_active;
  logic [LANES-1:0] core_din;

  int    n_checks = 0;
  int    n_errors = 0;
  int    rise_cnt = 0;
  int    fall_cnt = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_pause_ctrl #(.LANES(LANES), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sio_in(sio), .mode(mode),
    .core_rise_en(core_rise_en), .core_fall_en(core_fall_en),
    .core_din(core_din), .out_hiz(out_hiz), .hold_active(hold_active)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: sample queue plus behavioural pause rules
  logic [5:0]       q[$];
  int               m_st;
  logic             m_psck, e_rise, e_fall, e_hiz, e_held;
  logic [LANES-1:0] e_din;

  always @(posedge clk) begin
    if (rst) begin
      q = {};
      for (int i = 0; i < SYNC; i++) q.push_back(6'b10_1111);
      m_st = 0; m_psck = 1'b0;
      e_rise = 0; e_fall = 0; e_hiz = 1; e_held = 0; e_din = '0;
    end else begin
      logic [5:0] s;
      logic hok, h, up, dn, ok, scs, ssck;
      int nst, nl;
      s = q[0];
      scs = s[5]; ssck = s[4]; h = s[3];
      hok = (mode != 2'b10);
      up = ssck && !m_psck;
      dn = !ssck && m_psck;
      ok = !scs && (!hok || (h && m_st != 2));
      e_rise = up && ok;
      e_fall = dn && ok;
      if (up && ok) begin
        nl = (mode == 2'b01) ? 2 : (mode == 2'b10) ? 4 : 1;
        for (int i = 0; i < LANES; i++) e_din[i] = (i < nl) ? s[i] : 1'b0;
      end
      e_hiz = scs || (hok && (!h || m_st == 2));
      nst = m_st;
      if (scs || !hok) nst = 0;
      else if (m_st == 0) begin if (!h) nst = ssck ? 1 : 2; end
      else if (m_st == 1) begin if (h) nst = 0; else if (dn) nst = 2; end
      else begin if (h && !ssck) nst = 0; end
      m_st = nst;
      e_held = (nst == 2);
      m_psck = ssck;
      void'(q.pop_front());
      q.push_back({cs_n, sck, sio});
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk({phase, " rise"}, core_rise_en, e_rise);
      chk({phase, " fall"}, core_fall_en, e_fall);
      chk({phase, " din"},  core_din,     e_din);
      chk({phase, " hiz"},  out_hiz,      e_hiz);
      chk({phase, " held"}, hold_active,  e_held);
      rise_cnt += core_rise_en;
      fall_cnt += core_fall_en;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse(logic [3:0] v);
    sio = v; sck = 1'b1; wait_clk(4);
    sck = 1'b0; wait_clk(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int base_r, base_f;
    wait_clk(4);
    chk("R1 rise", core_rise_en, 0);
    chk("R1 fall", core_fall_en, 0);
    chk("R1 din",  core_din, 0);
    chk("R1 hiz",  out_hiz, 1);
    chk("R1 held", hold_active, 0);
    rst = 1'b0;

    phase = "R2"; cs_n = 1'b0; wait_clk(4);
    base_r = rise_cnt; base_f = fall_cnt;
    for (int i = 0; i < 8; i++) sck_pulse({1'b1, 3'(i * 3)});
    wait_clk(4);
    chk("R2 rises", rise_cnt - base_r, 8);
    chk("R2 falls", fall_cnt - base_f, 8);

    phase = "R3";
    sck_pulse(4'b1011); chk("R3 single", core_din, 4'b0001);
    mode = 2'b01; sck_pulse(4'b1110); chk("R3 dual", core_din, 4'b0010);
    mode = 2'b11; sck_pulse(4'b1111); chk("R3 alt", core_din, 4'b0001);
    mode = 2'b10; sck_pulse(4'b0101); chk("R3 quad", core_din, 4'b0101);
    sio = 4'hF; mode = 2'b00; wait_clk(4);

    phase = "R4"; base_r = rise_cnt;
    sio = 4'b0111; wait_clk(5);
    chk("R4 held", hold_active, 1);
    chk("R6 hiz", out_hiz, 1);
    sck_pulse(4'b0000); sck_pulse(4'b0001);
    chk("R4 masked", rise_cnt - base_r, 0);
    chk("R11 din", core_din, 4'b0101);
    sio = 4'b1000; wait_clk(5);
    chk("R7 resume", hold_active, 0);
    chk("R7 hiz", out_hiz, 0);
    // collision: hold falls with SCK falling
    sck = 1'b1; wait_clk(5); base_f = fall_cnt;
    sck = 1'b0; sio = 4'b0000; wait_clk(5);
    chk("R4 coincident fall", fall_cnt - base_f, 0);
    chk("R4 coincident held", hold_active, 1);
    sio = 4'b1000; wait_clk(5);
    // collision: hold falls with SCK rising
    base_r = rise_cnt;
    sck = 1'b1; sio = 4'b0000; wait_clk(5);
    chk("R4 coincident rise", rise_cnt - base_r, 0);

    phase = "R5";
    chk("R5 pending not held", hold_active, 0);
    chk("R6 hiz pending", out_hiz, 1);
    base_f = fall_cnt;
    sck = 1'b0; wait_clk(5);
    chk("R5 entered", hold_active, 1);
    chk("R5 edge consumed", fall_cnt - base_f, 0);

    phase = "R7";
    sck = 1'b1; wait_clk(4);
    sio = 4'b1000; wait_clk(5);
    chk("R7 still held", hold_active, 1);
    sck = 1'b0; wait_clk(5);
    chk("R7 released", hold_active, 0);
    base_r = rise_cnt;
    sck_pulse(4'b1001);
    chk("R7 resumes edges", rise_cnt - base_r, 1);
    chk("R7 din", core_din, 4'b0001);

    phase = "R10";
    sck = 1'b1; wait_clk(4);
    sio = 4'b0000; wait_clk(2);
    sio = 4'b1000; wait_clk(3);
    base_f = fall_cnt;
    sck = 1'b0; wait_clk(5);
    chk("R10 fall passes", fall_cnt - base_f, 1);
    chk("R10 not held", hold_active, 0);

    phase = "R8"; mode = 2'b10; wait_clk(2);
    base_r = rise_cnt;
    sio = 4'b0000; wait_clk(4);
    sck_pulse(4'b0110); sck_pulse(4'b0011);
    chk("R8 rises", rise_cnt - base_r, 2);
    chk("R8 held", hold_active, 0);
    chk("R8 hiz", out_hiz, 0);
    chk("R8 din", core_din, 4'b0011);

    phase = "R9"; mode = 2'b00; sio = 4'b1000; wait_clk(5);
    sio = 4'b0000; wait_clk(5);
    chk("R9 pre held", hold_active, 1);
    cs_n = 1'b1; wait_clk(5);
    chk("R9 abort", hold_active, 0);
    chk("R9 hiz", out_hiz, 1);
    base_r = rise_cnt;
    sck_pulse(4'b1111);
    chk("R9 no edges", rise_cnt - base_r, 0);
    sio = 4'hF; wait_clk(4);
    cs_n = 1'b0; wait_clk(5);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule